// File: doc/BRIEF.md
# Cyclic Successive-Approximation Time-to-Digital Converter Sequencer

This block is the digital half of a two-part time-interval digitizer. Between a start event and a stop event, a coarse counter counts whole reference-clock cycles. After the stop event, the block resolves the leftover fraction of a clock period one bit per cycle. It drives a binary trial word onto external delay adjusters. Each cycle it reads back one phase-detector decision, which says whether the adjusted edge pair places the residue above or below the trial. The decisions enter a shift register, most significant bit first. The block then forms the timestamp: the coarse count multiplied by a static "fine LSBs per clock period" factor, plus the fine code.

The controller is a four-state machine. ST_IDLE waits for a start; a start moves it to ST_COUNT. ST_COUNT increments the coarse counter every cycle, and a stop moves it to ST_RESOLVE. ST_RESOLVE consumes one decision per cycle, and after the decision for bit 0 it moves to ST_DONE. ST_DONE shows the result for one cycle and always returns to ST_IDLE. If the coarse counter would pass its maximum, it holds at full scale and raises an error flag. Only reset clears that flag.

Top module: `tdc_sar_ctrl`

## Requirements
- R1: After reset, busy_o, valid_o, err_o, ctrl_o and stamp_o are all zero.
- R2: A start_i sampled in ST_IDLE begins a conversion, and busy_o is high from the next cycle on. A stop_i sampled while idle has no effect: busy_o stays low and ctrl_o is unchanged.
- R3: The coarse count is the number of rising clock edges from the edge that samples start_i to the edge that samples stop_i, inclusive of the latter. A stop on the first edge after start therefore gives a count of 1.
- R4: In the cycle after the stop edge, ctrl_o holds only its most significant bit (bit FINE_W-1).
- R5: In each of the FINE_W resolve steps, bit b is the trial bit. A decision of 1 keeps it and a decision of 0 clears it, and bit b-1 is then set as the next trial. The fine code holds the decisions most significant first: the first decision is bit FINE_W-1.
- R6: valid_o is high for exactly one cycle, FINE_W cycles after the stop edge.
- R7: While valid_o is high, stamp_o equals coarse_count * scale_i + fine_code.
- R8: A start_i that arrives while busy_o is high, including the valid_o cycle, is ignored. The machine returns to idle after valid_o and the coarse count is not disturbed.
- R9: The coarse counter saturates at 2^CRS_W-1. An increment attempted at full scale sets err_o, and err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start event, sampled on the clock |
| stop_i | input | 1 | Stop event, sampled on the clock |
| scale_i | input | SCALE_W | Static count of fine LSBs per clock period |
| decide_i | input | 1 | Phase-detector decision for the current trial bit |
| ctrl_o | output | FINE_W | Binary delay-control trial word |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle result strobe |
| stamp_o | output | CRS_W+SCALE_W | Assembled timestamp |
| err_o | output | 1 | Sticky coarse-counter overflow flag |

## Verification
Two pairs of events can land on the same cycle. The first pair is the result strobe and a fresh start. The bench raises start_i exactly in the valid_o cycle and expects busy_o low with no new conversion on the next cycle. The second pair is the stop and counter saturation. Stops are placed one edge before full scale, exactly at full scale and beyond it, and the bench judges both the saturated timestamp and the point at which err_o first rises.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_RESOLVE = 2'd2,
        ST_DONE    = 2'd3
    } tdc_state_e;
endpackage

// File: rtl/tdc_coarse_cnt.sv
module tdc_coarse_cnt #(
    parameter int CRS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CRS_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CRS_W-1:0] FULL = {CRS_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i) begin
            if (count_o == FULL) begin
                ovf_o <= 1'b1;
            end else begin
                count_o <= count_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdc_sar_seq.sv
module tdc_sar_seq #(
    parameter int FINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              decide_i,
    output logic [FINE_W-1:0] trial_o,
    output logic              last_o
);
    localparam logic [FINE_W-1:0] TOP_BIT = FINE_W'(1) << (FINE_W - 1);

    logic [FINE_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_o <= '0;
            ptr_q   <= '0;
        end else if (load_i) begin
            trial_o <= TOP_BIT;
            ptr_q   <= TOP_BIT;
        end else if (step_i) begin
            trial_o <= (decide_i ? trial_o : (trial_o & ~ptr_q)) | (ptr_q >> 1);
            ptr_q   <= ptr_q >> 1;
        end
    end

    assign last_o = ptr_q[0];
endmodule

// File: rtl/tdc_dec_shreg.sv
module tdc_dec_shreg #(
    parameter int FINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [FINE_W-1:0] code_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
        end else if (clr_i) begin
            code_o <= '0;
        end else if (shift_i) begin
            code_o <= {code_o[FINE_W-2:0], bit_i};
        end
    end
endmodule

// File: rtl/tdc_sar_ctrl.sv
module tdc_sar_ctrl
    import tdc_pkg::*;
#(
    parameter int FINE_W  = 13,
    parameter int CRS_W   = 16,
    parameter int SCALE_W = 14,
    localparam int TS_W   = CRS_W + SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               decide_i,
    output logic [FINE_W-1:0]  ctrl_o,
    output logic               busy_o,
    output logic               valid_o,
    output logic [TS_W-1:0]    stamp_o,
    output logic               err_o
);
    tdc_state_e state_q, state_d;

    logic              counting;
    logic              resolving;
    logic              accept;
    logic              stop_hit;
    logic              last_step;
    logic [CRS_W-1:0]  coarse_q;
    logic [FINE_W-1:0] fine_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)   state_d = ST_COUNT;
            ST_COUNT:   if (stop_i)    state_d = ST_RESOLVE;
            ST_RESOLVE: if (last_step) state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        valid_o   = (state_q == ST_DONE);
        counting  = (state_q == ST_COUNT);
        resolving = (state_q == ST_RESOLVE);
        accept    = (state_q == ST_IDLE) && start_i;
        stop_hit  = counting && stop_i;
    end

    tdc_coarse_cnt #(.CRS_W(CRS_W)) i_coarse (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .inc_i   (counting),
        .count_o (coarse_q),
        .ovf_o   (err_o)
    );

    tdc_sar_seq #(.FINE_W(FINE_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (stop_hit),
        .step_i   (resolving),
        .decide_i (decide_i),
        .trial_o  (ctrl_o),
        .last_o   (last_step)
    );

    tdc_dec_shreg #(.FINE_W(FINE_W)) i_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (stop_hit),
        .shift_i (resolving),
        .bit_i   (decide_i),
        .code_o  (fine_q)
    );

    assign stamp_o = TS_W'(coarse_q) * TS_W'(scale_i) + TS_W'(fine_q);
endmodule

// File: rtl/tdc_sar_ctrl_chk.sv
module tdc_sar_ctrl_chk #(
    parameter int FINE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              counting,
    input logic              busy_o,
    input logic              valid_o,
    input logic              err_o,
    input logic [FINE_W-1:0] ctrl_o,
    input logic [FINE_W-1:0] fine_q
);
    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_msb_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && stop_i) |=> (ctrl_o == (FINE_W'(1) << (FINE_W - 1))));

    p_code_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (fine_q == ctrl_o));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !valid_o) |=> busy_o);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !busy_o);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

bind tdc_sar_ctrl tdc_sar_ctrl_chk #(.FINE_W(FINE_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .counting (counting),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .err_o    (err_o),
    .ctrl_o   (ctrl_o),
    .fine_q   (fine_q)
);

// File: tb/test_tdc_sar_ctrl.sv
`timescale 1ns/1ps
module test_tdc_sar_ctrl;
    localparam int FINE_W  = 13;
    localparam int CRS_W   = 10;
    localparam int SCALE_W = 14;
    localparam int TS_W    = CRS_W + SCALE_W;
    localparam longint CMAX = (64'd1 << CRS_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic               stop_i = 1'b0;
    logic [SCALE_W-1:0] scale_i = '0;
    logic               decide_i = 1'b0;
    logic [FINE_W-1:0]  ctrl_o;
    logic               busy_o;
    logic               valid_o;
    logic [TS_W-1:0]    stamp_o;
    logic               err_o;

    int checks = 0;
    int errors = 0;
    bit err_exp = 1'b0;
    int cycles = 0;

    always #4 clk = ~clk;

    tdc_sar_ctrl #(.FINE_W(FINE_W), .CRS_W(CRS_W), .SCALE_W(SCALE_W)) i_tdc_sar_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .scale_i(scale_i), .decide_i(decide_i), .ctrl_o(ctrl_o),
        .busy_o(busy_o), .valid_o(valid_o), .stamp_o(stamp_o), .err_o(err_o)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint trial_exp(int resid, int b);
        longint hi;
        hi = longint'(resid) & ~((64'd1 << (b + 1)) - 1);
        return hi | (64'd1 << b);
    endfunction

    function automatic longint stamp_exp(int k, int resid, int scale);
        longint c;
        c = (longint'(k) > CMAX) ? CMAX : longint'(k);
        return c * scale + resid;
    endfunction

    // one full conversion with an ideal residue comparator
    task automatic convert(int k, int resid, int scale, bit collide, bit mid_start);
        @(negedge clk);
        scale_i = SCALE_W'(scale);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", busy_o, 1);
        for (int j = 1; j <= k; j++) begin
            stop_i  = (j == k);
            start_i = mid_start && (j == (k + 1) / 2) && (j != k);
            @(posedge clk);
            @(negedge clk);
        end
        stop_i  = 1'b0;
        start_i = 1'b0;
        if (longint'(k) > CMAX) err_exp = 1'b1;
        check("R4 msb trial", ctrl_o, longint'(1) << (FINE_W - 1));
        for (int b = FINE_W - 1; b >= 0; b--) begin
            check("R5 trial word", ctrl_o, trial_exp(resid, b));
            check("R6 no early valid", valid_o, 0);
            decide_i = (resid >> b) & 1;
            @(posedge clk);
            @(negedge clk);
        end
        decide_i = 1'b0;
        check("R6 valid strobe", valid_o, 1);
        check("R3 R7 stamp", stamp_o, stamp_exp(k, resid, scale));
        check("R9 err flag", err_o, err_exp);
        if (collide) start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R6 valid single cycle", valid_o, 0);
        check("R8 idle after done", busy_o, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_7DC0));
        repeat (3) @(negedge clk);
        check("R1 busy reset", busy_o, 0);
        check("R1 valid reset", valid_o, 0);
        check("R1 err reset", err_o, 0);
        check("R1 ctrl reset", ctrl_o, 0);
        check("R1 stamp reset", stamp_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // stop while idle is ignored
        stop_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stop_i = 1'b0;
        check("R2 stop in idle busy", busy_o, 0);
        check("R2 stop in idle ctrl", ctrl_o, 0);

        // directed corners
        convert(1, 0, 1, 1'b0, 1'b0);
        convert(1, 8191, 8192, 1'b1, 1'b0);
        convert(7, 4096, 100, 1'b0, 1'b1);
        convert(2, 4095, 16383, 1'b1, 1'b1);

        // random mix
        for (int n = 0; n < 20; n++) begin
            int k;
            int r;
            int s;
            k = 1 + int'($urandom % 40);
            r = int'($urandom % 8192);
            s = 1 + int'($urandom % 16383);
            convert(k, r, s, 1'($urandom % 2), 1'($urandom % 2));
        end

        // saturation boundary
        convert(int'(CMAX), 1234, 5000, 1'b0, 1'b0);
        convert(int'(CMAX) + 1, 77, 5000, 1'b1, 1'b0);
        convert(3, 2, 9, 1'b0, 1'b0);
        convert(int'(CMAX) + 50, 8000, 3, 1'b0, 1'b0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule